// File: doc/BRIEF.md
# Overlapped Block Input Load Controller

This block controls how input samples are written into the sample buffer of a transform engine when consecutive transform blocks overlap. An external sample strobe arrives with no fixed relation to the system clock. The block synchronises it, finds its rising edges, and divides them by one, two or four according to the selected overlap. Each accepted strobe becomes a single buffer write with its own address. The strobe divider lets the input side and the output side share one strobe source while the output runs faster than the input.

A load is armed with a one-cycle start request. The block latches the block length (a power of two), the overlap setting and the preload choice at that point. The load flag stays high while the normal block is being collected. In preload mode with overlap, loading carries on after the flag drops. The block collects one more hop of samples (half a block at 50% overlap, a quarter block at 75%), so every overlapped transform of the set can run with no new input. A one-cycle ready pulse marks the end of the load. While a transform runs in preload mode, strobes are discarded, so loading and transforming never overlap. A configuration whose samples would not fit in the buffer is refused.

Top module: `olc_load_ctl`

## Requirements
- R1: After reset, wr_en, load_flag and blk_ready are 0 and wr_addr is 0.
- R2: Strobe division follows ovl_mode (0 = none, 1 = half/50%, 2 = quarter/75%). After an accepted start, the 1st synchronised strobe rising edge is accepted, followed by every 1st, 2nd or 4th edge after it. Exactly (M-1)*D+1 strobes give M writes, where D is 1, 2 or 4.
- R3: load_flag rises only in the cycle after an accepted start. It is high for the first N-1 writes of a load (N = 2^blk_log2) and is already low in the cycle of the Nth write.
- R4: When preload = 1 and the overlap is half or quarter, a load writes N + N/2 or N + N/4 samples in total. With no overlap it writes N.
- R5: When preload = 0, a load writes exactly N samples whatever the overlap setting.
- R6: blk_ready is a single-cycle pulse in the cycle after the final write of a load. Strobes after that pulse cause no writes until the next start.
- R7: wr_addr increases by one per write, modulo 2^ADDR_W, and continues from load to load.
- R8: In preload mode, strobes that occur while xform_busy = 1 are discarded and do not advance the divider. With preload = 0, xform_busy has no effect.
- R9: A start is ignored (no load_flag, no writes) if blk_log2 < 2, if blk_log2 > ADDR_W, if ovl_mode = 3, or if the total sample count exceeds 2^ADDR_W.
- R10: A start request during an ongoing load is ignored and does not change the load's length.
- R11: A strobe held high for many cycles produces at most one write, and writes never occur in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a load |
| blk_log2 | input | $clog2(ADDR_W+1) | log2 of the normal block length |
| ovl_mode | input | 2 | 0 none, 1 half, 2 quarter, 3 reserved |
| preload | input | 1 | Load the extra overlap hop after the normal block |
| xform_busy | input | 1 | Transform running; blocks loading in preload mode |
| strobe_in | input | 1 | Asynchronous sample strobe |
| wr_en | output | 1 | Buffer write enable, one cycle per sample |
| wr_addr | output | ADDR_W | Buffer write address |
| load_flag | output | 1 | High while the normal block is loading |
| blk_ready | output | 1 | One-cycle pulse after the final write |

## Verification
The hardest behaviour to reach from the ports is the exact edge of the divider and the preload phase. The question is whether the final extra sample arrives on precisely the (M-1)*D+1-th strobe, and nothing arrives after it. The bench sweeps every block length, overlap and preload choice of a 64-entry buffer. For each case it sends exactly the minimum strobe count, checks the totals, then sends surplus strobes to show that they are dropped. Separate runs hold xform_busy across strobes in both modes, issue a second start in the middle of a load, and hold one strobe high for many cycles.

// File: rtl/olc_pkg.sv
package olc_pkg;
   typedef enum logic [1:0] {
      OVL_NONE    = 2'd0,
      OVL_HALF    = 2'd1,
      OVL_QUARTER = 2'd2,
      OVL_RSVD    = 2'd3
   } ovl_e;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_MAIN  = 2'd1,
      SEQ_EXTRA = 2'd2,
      SEQ_DONE  = 2'd3
   } seq_e;

   // Divider mask: accepted edge when the phase counter is zero.
   function automatic logic [1:0] div_mask(ovl_e m);
      case (m)
         OVL_HALF:    return 2'b01;
         OVL_QUARTER: return 2'b11;
         default:     return 2'b00;
      endcase
   endfunction

   // Right shift giving one hop of an overlapped block.
   function automatic int unsigned hop_shift(ovl_e m);
      return (m == OVL_QUARTER) ? 2 : 1;
   endfunction
endpackage

// File: rtl/olc_strobe_sync.sv
module olc_strobe_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_in,
   output logic rise_o
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("olc_strobe_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] chain;
   logic                   last_q;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= strobe_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[SYNC_STAGES-1];
   end

   assign rise_o = chain[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/olc_strobe_div.sv
module olc_strobe_div
   import olc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic rise_i,
   input  logic enable,
   input  ovl_e ovl,
   output logic take_o
);
   logic [1:0] phase_q;
   logic [1:0] mask;
   logic       counted;

   assign mask    = div_mask(ovl);
   assign counted = rise_i & enable;
   assign take_o  = counted & ((phase_q & mask) == 2'b00);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase_q <= 2'b00;
      else if (clear)   phase_q <= 2'b00;
      else if (counted) phase_q <= (phase_q + 2'b01) & mask;
   end
endmodule

// File: rtl/olc_plan.sv
module olc_plan
   import olc_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int LOG_W  = 4,
   localparam int LEN_W = ADDR_W + 2
) (
   input  logic [LOG_W-1:0] blk_log2,
   input  logic [1:0]       ovl_mode,
   input  logic             preload,
   output logic             legal,
   output logic [LEN_W-1:0] main_len,
   output logic [LEN_W-1:0] total_len
);
   localparam logic [LEN_W-1:0] CAPACITY = LEN_W'(1) << ADDR_W;

   ovl_e             ovl;
   logic [LEN_W-1:0] extra;
   logic             size_ok;

   assign ovl     = ovl_e'(ovl_mode);
   assign size_ok = (int'(blk_log2) >= 2) && (int'(blk_log2) <= ADDR_W);

   always_comb begin
      main_len = size_ok ? (LEN_W'(1) << blk_log2) : '0;
      if (preload && (ovl == OVL_HALF || ovl == OVL_QUARTER))
         extra = main_len >> hop_shift(ovl);
      else
         extra = '0;
      total_len = main_len + extra;
      legal = size_ok && (ovl != OVL_RSVD) && (total_len <= CAPACITY);
   end
endmodule

// File: rtl/olc_seq.sv
module olc_seq
   import olc_pkg::*;
#(
   parameter int LEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_ok,
   input  logic             take,
   input  logic [LEN_W-1:0] main_len,
   input  logic [LEN_W-1:0] total_len,
   output logic             idle_o,
   output logic             active_o,
   output logic             wr_en_o,
   output logic             load_flag_o,
   output logic             blk_ready_o
);
   seq_e             state_q;
   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] cnt_nx;

   assign cnt_nx   = cnt_q + LEN_W'(1);
   assign idle_o   = (state_q == SEQ_IDLE);
   assign active_o = (state_q == SEQ_MAIN) || (state_q == SEQ_EXTRA);
   assign load_flag_o = (state_q == SEQ_MAIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= SEQ_IDLE;
         cnt_q       <= '0;
         wr_en_o     <= 1'b0;
         blk_ready_o <= 1'b0;
      end else begin
         wr_en_o     <= 1'b0;
         blk_ready_o <= 1'b0;
         case (state_q)
            SEQ_IDLE: begin
               if (start_ok) begin
                  state_q <= SEQ_MAIN;
                  cnt_q   <= '0;
               end
            end
            SEQ_MAIN: begin
               if (take) begin
                  wr_en_o <= 1'b1;
                  cnt_q   <= cnt_nx;
                  if (cnt_nx == total_len)     state_q <= SEQ_DONE;
                  else if (cnt_nx == main_len) state_q <= SEQ_EXTRA;
               end
            end
            SEQ_EXTRA: begin
               if (take) begin
                  wr_en_o <= 1'b1;
                  cnt_q   <= cnt_nx;
                  if (cnt_nx == total_len) state_q <= SEQ_DONE;
               end
            end
            SEQ_DONE: begin
               blk_ready_o <= 1'b1;
               state_q     <= SEQ_IDLE;
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/olc_addr_gen.sv
module olc_addr_gen #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   output logic [ADDR_W-1:0] wr_addr_o
);
   logic [ADDR_W-1:0] ptr_q;

   // Natural wrap of an ADDR_W-bit counter gives modulo-capacity order.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q     <= '0;
         wr_addr_o <= '0;
      end else if (take) begin
         wr_addr_o <= ptr_q;
         ptr_q     <= ptr_q + ADDR_W'(1);
      end
   end
endmodule

// File: rtl/olc_load_ctl.sv
module olc_load_ctl
   import olc_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int SYNC_STAGES = 2,
   localparam int LOG_W      = $clog2(ADDR_W + 1),
   localparam int LEN_W      = ADDR_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LOG_W-1:0]  blk_log2,
   input  logic [1:0]        ovl_mode,
   input  logic              preload,
   input  logic              xform_busy,
   input  logic              strobe_in,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              load_flag,
   output logic              blk_ready
);
   if (ADDR_W < 2 || ADDR_W > 24) begin : g_bad_addr
      $error("olc_load_ctl: ADDR_W out of range");
   end

   logic             legal;
   logic [LEN_W-1:0] main_len, total_len;
   logic [LEN_W-1:0] main_q, total_q;
   ovl_e             ovl_q;
   logic             pre_q;
   logic             idle, active, start_ok;
   logic             rise, take, div_en;

   olc_plan #(.ADDR_W(ADDR_W), .LOG_W(LOG_W)) u_plan (
      .blk_log2 (blk_log2),
      .ovl_mode (ovl_mode),
      .preload  (preload),
      .legal    (legal),
      .main_len (main_len),
      .total_len(total_len)
   );

   assign start_ok = start & idle & legal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_q  <= '0;
         total_q <= '0;
         ovl_q   <= OVL_NONE;
         pre_q   <= 1'b0;
      end else if (start_ok) begin
         main_q  <= main_len;
         total_q <= total_len;
         ovl_q   <= ovl_e'(ovl_mode);
         pre_q   <= preload;
      end
   end

   olc_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_in(strobe_in),
      .rise_o   (rise)
   );

   // In preload mode no sample is taken while the transform runs.
   assign div_en = active & ~(pre_q & xform_busy);

   olc_strobe_div u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (start_ok),
      .rise_i(rise),
      .enable(div_en),
      .ovl   (ovl_q),
      .take_o(take)
   );

   olc_seq #(.LEN_W(LEN_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_ok   (start_ok),
      .take       (take),
      .main_len   (main_q),
      .total_len  (total_q),
      .idle_o     (idle),
      .active_o   (active),
      .wr_en_o    (wr_en),
      .load_flag_o(load_flag),
      .blk_ready_o(blk_ready)
   );

   olc_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .wr_addr_o(wr_addr)
   );
endmodule

// File: rtl/olc_load_ctl_chk.sv
module olc_load_ctl_chk #(
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              load_flag,
   input logic              blk_ready
);
   logic [ADDR_W-1:0] next_addr;
   logic              seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         next_addr <= '0;
         seen      <= 1'b0;
      end else if (wr_en) begin
         next_addr <= wr_addr + ADDR_W'(1);
         seen      <= 1'b1;
      end
   end

   AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);                                        // R11
   AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      blk_ready |=> !blk_ready);                                // R6
   AST_READY_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
      blk_ready |-> $past(wr_en));                              // R6
   AST_FLAG_FALL_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(load_flag) |-> wr_en);                              // R3
   AST_FLAG_RISE_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(load_flag) |-> $past(start));                       // R3
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && seen) |-> (wr_addr == next_addr));              // R7
endmodule

bind olc_load_ctl olc_load_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .load_flag(load_flag),
   .blk_ready(blk_ready)
);

// File: tb/olc_load_ctl_test.sv
`timescale 1ns/1ps
module olc_load_ctl_test;
   localparam int AW  = 6;
   localparam int LW  = $clog2(AW + 1);
   localparam int CAP = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [LW-1:0] blk_log2 = '0;
   logic [1:0]    ovl_mode = 2'd0;
   logic          preload = 1'b0;
   logic          xform_busy = 1'b0;
   logic          strobe_in = 1'b0;
   logic          wr_en, load_flag, blk_ready;
   logic [AW-1:0] wr_addr;

   int errors = 0, checks = 0;
   int wcount = 0, rcount = 0, flagw = 0, addr_err = 0, exp_ptr = 0;
   logic finished = 1'b0;

   always #2.5 clk = ~clk;

   olc_load_ctl #(.ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .blk_log2(blk_log2),
      .ovl_mode(ovl_mode), .preload(preload), .xform_busy(xform_busy),
      .strobe_in(strobe_in), .wr_en(wr_en), .wr_addr(wr_addr),
      .load_flag(load_flag), .blk_ready(blk_ready)
   );

   always @(negedge clk) if (rst_n) begin
      if (wr_en) begin
         if (int'(wr_addr) != exp_ptr) addr_err++;
         exp_ptr = (exp_ptr + 1) % CAP;
         wcount++;
         if (load_flag) flagw++;
      end
      if (blk_ready) rcount++;
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic strobes(int n, int hi, int lo);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) strobe_in = 1'b1;
         repeat (hi) @(negedge clk);
         strobe_in = 1'b0;
         repeat (lo) @(negedge clk);
      end
      repeat (6) @(negedge clk);
   endtask

   task automatic clear_counts();
      wcount = 0; rcount = 0; flagw = 0; addr_err = 0;
   endtask

   task automatic do_start(int lg, int ov, bit pre);
      @(negedge clk);
      blk_log2 = LW'(lg); ovl_mode = 2'(ov); preload = pre; start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   function automatic int div_of(int ov);
      return (ov == 2) ? 4 : (ov == 1) ? 2 : 1;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 wr_en", wr_en, 0);
      chk("R1 load_flag", load_flag, 0);
      chk("R1 blk_ready", blk_ready, 0);
      chk("R1 wr_addr", wr_addr, 0);

      // Sweep over every size, overlap and preload choice (R2 R4 R5 R9).
      for (int lg = 0; lg <= AW; lg++)
         for (int ov = 0; ov < 4; ov++)
            for (int pre = 0; pre < 2; pre++) begin
               int n, m, d;
               bit legal;
               n = 1 << lg;
               d = div_of(ov);
               m = n;
               if (pre == 1 && ov == 1) m = n + n / 2;
               if (pre == 1 && ov == 2) m = n + n / 4;
               legal = (lg >= 2) && (ov != 3) && (m <= CAP);
               if (!legal) m = 0;
               clear_counts();
               do_start(lg, ov, pre[0]);
               chk(legal ? "R3 flag after start" : "R9 flag after bad start",
                   load_flag, legal ? 1 : 0);
               if (legal) strobes((m - 1) * d + 1, 1 + (lg % 3), 2);
               else       strobes(8, 1, 2);
               chk(pre ? "R2 R4 write count" : "R2 R5 write count", wcount, m);
               chk("R6 ready count", rcount, legal ? 1 : 0);
               chk("R3 writes under flag", flagw, legal ? n - 1 : 0);
               chk("R7 address order", addr_err, 0);
               clear_counts();
               strobes(2 * d + 1, 1, 2);
               chk("R6 no writes after ready", wcount, 0);
               chk("R3 flag low at end", load_flag, 0);
            end

      // R8: busy discards strobes in preload mode.
      clear_counts();
      do_start(4, 1, 1'b1);
      xform_busy = 1'b1;
      strobes(10, 1, 2);
      chk("R8 busy blocks preload", wcount, 0);
      xform_busy = 1'b0;
      strobes(23 * 2 + 1, 1, 2);
      chk("R8 resume after busy", wcount, 24);
      chk("R8 ready after busy", rcount, 1);

      // R8: busy ignored without preload.
      clear_counts();
      do_start(3, 0, 1'b0);
      xform_busy = 1'b1;
      strobes(8, 1, 2);
      xform_busy = 1'b0;
      chk("R8 busy ignored", wcount, 8);
      chk("R8 ready no preload", rcount, 1);

      // R10: restart mid-load has no effect.
      clear_counts();
      do_start(3, 0, 1'b0);
      strobes(3, 1, 2);
      do_start(5, 0, 1'b0);
      chk("R10 flag still high", load_flag, 1);
      strobes(5, 1, 2);
      chk("R10 length unchanged", wcount, 8);
      chk("R10 single ready", rcount, 1);

      // R11: a long strobe gives one write.
      clear_counts();
      do_start(2, 0, 1'b0);
      strobes(1, 20, 3);
      chk("R11 long strobe", wcount, 1);
      strobes(3, 1, 2);
      chk("R11 remaining writes", wcount, 4);
      chk("R7 address order final", addr_err, 0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule